// File: doc/BRIEF.md
# Predicate Counter Decoder

This block turns a 16-bit counter-form predicate word into the pieces a vector datapath needs: how many elements are active, the log2 element stride and an invert flag. It also expands them into one predicate bit per element of the current vector. The word carries its own element size. That size is the position of the lowest set bit among bits 0 to 3. The count sits in the bits above that marker, and bit 15 selects inversion. The decoder rescales the count from the element size in the word to the element size of the vector operation. When the vector elements are wider, it divides and rounds up. When they are narrower, it multiplies and reports a stride.

Decoding is purely combinational. A one-cycle valid strobe captures the results into output registers. The vector length is given in bytes and must be a power of two from 16 to 256. The element size code selects 8, 16, 32 or 64-bit elements (codes 0 to 3).

Top module: `pred_counter_decoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, out_valid is 0 and out_count, out_lg2_stride, out_invert and out_mask are all zero. Asserting arst_n low clears them at once.
- R2: A cycle with in_valid high captures the decode at that clock edge, and out_valid is high for exactly the following cycle. Without a strobe, changes on ctr_word, vl_bytes or elem_size leave all outputs unchanged, and out_valid stays low.
- R3: If ctr_word[3:0] is zero, then count, stride and invert are all zero and the mask is all zero, whatever bits 15:4 hold.
- R4: The word's element size code equals the number of trailing zero bits of ctr_word: bit 0 set gives code 0 and bit 3 lowest gives code 3.
- R5: The base count is (ctr_word AND ((vl_bytes << 3) - 1)) shifted right by (word size code + 1). Bits above that mask are ignored.
- R6: When ctr_word[3:0] is nonzero, out_invert equals ctr_word[15].
- R7: If the word size code is below elem_size, the count is shifted right by the difference. It is incremented by one if any nonzero bits were shifted out. The stride is 0.
- R8: If the word size code is above elem_size, the count is shifted left by the difference and out_lg2_stride equals the difference. If the codes are equal, the count passes through unchanged with stride 0.
- R9: out_mask bit i, for i below vl_bytes >> elem_size, is set when i < count and i is a multiple of 2^stride. All bits at or above vl_bytes >> elem_size are zero.
- R10: When invert is set, every mask bit below vl_bytes >> elem_size takes the opposite value to the one R9 gives. Bits beyond that limit stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe that captures the decode of the current inputs |
| ctr_word | input | 16 | Counter-form predicate word |
| vl_bytes | input | 9 | Vector length in bytes (power of two, 16 to 256) |
| elem_size | input | 2 | Vector element size code: 0=8, 1=16, 2=32, 3=64 bits |
| out_valid | output | 1 | High for one cycle after a strobe |
| out_count | output | 13 | Number of elements covered after rescaling |
| out_lg2_stride | output | 2 | Log2 of the element stride |
| out_invert | output | 1 | Predicate inversion flag |
| out_mask | output | 256 | Expanded per-element predicate, bit i for element i |

## Verification
The vectors aim at the rescaling edges. A word that divides exactly and one that leaves a remainder are both applied when the vector elements are wider than the word's. A design that always rounded up, or never did, gives a count that is off by one in one of the two. Words with bits above the length-dependent count mask, and words whose low nibble is clear while bit 15 is set, show whether masking or the zero-marker rule was skipped. A design that got these wrong reports a huge count or a spurious inversion. Strided, inverted and over-long counts show whether the mask leaks ones past the last element, or inverts elements that do not exist. The bench also changes inputs without a strobe and applies back-to-back strobes to catch outputs that are not properly held or captured.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ESZ_W  = 2;
  localparam int unsigned INV_BIT = 15;
  localparam int unsigned MARK_W = 4;

  typedef logic [ESZ_W-1:0] esz_t;

  // position of the lowest set bit of the size marker nibble (0 when empty)
  function automatic esz_t marker_pos(input logic [MARK_W-1:0] nib);
    esz_t pos;
    if (nib[0])      pos = 2'd0;
    else if (nib[1]) pos = 2'd1;
    else if (nib[2]) pos = 2'd2;
    else             pos = 2'd3;
    return pos;
  endfunction
endpackage

// File: rtl/pcd_rst_sync.sv
module pcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pcd_field_decode.sv
module pcd_field_decode
  import pcd_pkg::*;
#(
  parameter int unsigned MAX_VL_BYTES = 256,
  localparam int unsigned LG_MAX = $clog2(MAX_VL_BYTES),
  localparam int unsigned VL_W   = LG_MAX + 1,
  localparam int unsigned CNT_W  = LG_MAX + 5
) (
  input  logic [WORD_W-1:0] ctr_word,
  input  logic [VL_W-1:0]   vl_bytes,
  input  esz_t              elem_size,
  output logic [CNT_W-1:0]  count,
  output esz_t              lg2_stride,
  output logic              invert
);
  logic              present;
  esz_t              word_esz;
  esz_t              diff;
  logic [WORD_W-1:0] vl_p2;
  logic [WORD_W-1:0] cnt_keep;
  logic [WORD_W-1:0] raw_w;
  logic [CNT_W-1:0]  raw;
  logic [CNT_W-1:0]  trunc;
  logic              spill;

  always_comb begin
    present  = |ctr_word[MARK_W-1:0];
    word_esz = marker_pos(ctr_word[MARK_W-1:0]);

    // smallest power of two not below the vector length
    vl_p2 = WORD_W'(1) << LG_MAX;
    for (int k = LG_MAX; k >= 0; k--) begin
      if ((WORD_W'(1) << k) >= WORD_W'(vl_bytes)) vl_p2 = WORD_W'(1) << k;
    end
    cnt_keep = (vl_p2 << 3) - WORD_W'(1);
    raw_w    = (ctr_word & cnt_keep) >> ({1'b0, word_esz} + 3'd1);
    raw      = CNT_W'(raw_w);

    diff       = '0;
    trunc      = '0;
    spill      = 1'b0;
    count      = '0;
    lg2_stride = '0;
    invert     = 1'b0;

    if (present) begin
      invert = ctr_word[INV_BIT];
      if (word_esz < elem_size) begin
        diff  = elem_size - word_esz;
        trunc = raw >> diff;
        spill = (trunc << diff) != raw;
        count = trunc + CNT_W'(spill);
      end else if (word_esz > elem_size) begin
        diff       = word_esz - elem_size;
        count      = raw << diff;
        lg2_stride = diff;
      end else begin
        count = raw;
      end
    end
  end
endmodule

// File: rtl/pcd_mask_expand.sv
module pcd_mask_expand
  import pcd_pkg::*;
#(
  parameter int unsigned MAX_VL_BYTES = 256,
  localparam int unsigned LG_MAX = $clog2(MAX_VL_BYTES),
  localparam int unsigned VL_W   = LG_MAX + 1,
  localparam int unsigned CNT_W  = LG_MAX + 5
) (
  input  logic [CNT_W-1:0]        count,
  input  esz_t                    lg2_stride,
  input  logic                    invert,
  input  logic [VL_W-1:0]         vl_bytes,
  input  esz_t                    elem_size,
  output logic [MAX_VL_BYTES-1:0] mask
);
  logic [VL_W-1:0]  n_elems;
  logic [CNT_W-1:0] stride_low;

  always_comb begin
    n_elems    = vl_bytes >> elem_size;
    stride_low = (CNT_W'(1) << lg2_stride) - CNT_W'(1);
  end

  for (genvar gi = 0; gi < MAX_VL_BYTES; gi++) begin : g_elem
    localparam logic [CNT_W-1:0] IDX = CNT_W'(gi);
    localparam logic [VL_W-1:0]  POS = VL_W'(gi);
    logic hit;
    assign hit      = (IDX < count) && ((IDX & stride_low) == '0);
    assign mask[gi] = (POS < n_elems) && (hit ^ invert);
  end
endmodule

// File: rtl/pred_counter_decoder.sv
module pred_counter_decoder
  import pcd_pkg::*;
#(
  parameter int unsigned MAX_VL_BYTES = 256,
  localparam int unsigned LG_MAX = $clog2(MAX_VL_BYTES),
  localparam int unsigned VL_W   = LG_MAX + 1,
  localparam int unsigned CNT_W  = LG_MAX + 5
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       ctr_word,
  input  logic [VL_W-1:0]         vl_bytes,
  input  logic [ESZ_W-1:0]        elem_size,
  output logic                    out_valid,
  output logic [CNT_W-1:0]        out_count,
  output logic [ESZ_W-1:0]        out_lg2_stride,
  output logic                    out_invert,
  output logic [MAX_VL_BYTES-1:0] out_mask
);
  logic                    rst_q_n;
  logic [CNT_W-1:0]        cnt_c;
  esz_t                    stride_c;
  logic                    inv_c;
  logic [MAX_VL_BYTES-1:0] mask_c;

  logic                    valid_q, valid_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  esz_t                    stride_q, stride_d;
  logic                    inv_q, inv_d;
  logic [MAX_VL_BYTES-1:0] mask_q, mask_d;

  pcd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_q_n)
  );

  pcd_field_decode #(.MAX_VL_BYTES(MAX_VL_BYTES)) i_decode (
    .ctr_word   (ctr_word),
    .vl_bytes   (vl_bytes),
    .elem_size  (elem_size),
    .count      (cnt_c),
    .lg2_stride (stride_c),
    .invert     (inv_c)
  );

  pcd_mask_expand #(.MAX_VL_BYTES(MAX_VL_BYTES)) i_expand (
    .count      (cnt_c),
    .lg2_stride (stride_c),
    .invert     (inv_c),
    .vl_bytes   (vl_bytes),
    .elem_size  (elem_size),
    .mask       (mask_c)
  );

  // next state: capture on strobe, otherwise hold
  always_comb begin
    valid_d  = in_valid;
    cnt_d    = cnt_q;
    stride_d = stride_q;
    inv_d    = inv_q;
    mask_d   = mask_q;
    if (in_valid) begin
      cnt_d    = cnt_c;
      stride_d = stride_c;
      inv_d    = inv_c;
      mask_d   = mask_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q  <= 1'b0;
      cnt_q    <= '0;
      stride_q <= '0;
      inv_q    <= 1'b0;
      mask_q   <= '0;
    end else begin
      valid_q  <= valid_d;
      cnt_q    <= cnt_d;
      stride_q <= stride_d;
      inv_q    <= inv_d;
      mask_q   <= mask_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_count      = cnt_q;
  assign out_lg2_stride = stride_q;
  assign out_invert     = inv_q;
  assign out_mask       = mask_q;

  // R2: strobe produces a one-cycle valid
  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  // R2: no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && $stable(out_count) && $stable(out_mask)
                   && $stable(out_invert) && $stable(out_lg2_stride)));

  // R3: empty marker nibble yields an empty result
  p_empty_marker_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && ctr_word[3:0] == 4'h0) |=>
      (out_count == '0 && out_lg2_stride == '0 && !out_invert && out_mask == '0));

  // R8: a strided count is a multiple of its stride
  p_stride_aligned_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> (((out_count >> out_lg2_stride) << out_lg2_stride) == out_count));

  // R9: no more active bits than elements
  p_mask_range_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |-> ($countones(mask_c) <= int'(vl_bytes >> elem_size)));

  // R10: element zero reflects the invert bit when the count is nonzero
  p_lead_elem_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && ctr_word[3:0] != 4'h0 && cnt_c != '0) |-> (mask_c[0] == !ctr_word[INV_BIT]));
endmodule

// File: tb/test_pred_counter_decoder.sv
module test_pred_counter_decoder;
  localparam int unsigned NB = 256;
  localparam int unsigned VW = 9;
  localparam int unsigned CW = 13;

  typedef struct packed {
    logic [15:0]   ctr;
    logic [VW-1:0] vl;
    logic [1:0]    esz;
    logic [CW-1:0] cnt;
    logic [1:0]    stride;
    logic          inv;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{16'h80F0, 9'd256, 2'd0, 13'd0,   2'd0, 1'b0},  // R3 empty marker, bit15 set
    '{16'h0015, 9'd16,  2'd0, 13'd10,  2'd0, 1'b0},  // R4 R5 code 0
    '{16'h00FF, 9'd16,  2'd0, 13'd63,  2'd0, 1'b0},  // R9 count past end
    '{16'h8015, 9'd16,  2'd0, 13'd10,  2'd0, 1'b1},  // R6 R10 inverted
    '{16'h0016, 9'd32,  2'd1, 13'd5,   2'd0, 1'b0},  // R4 code 1
    '{16'h001D, 9'd32,  2'd3, 13'd2,   2'd0, 1'b0},  // R7 round up
    '{16'h0021, 9'd32,  2'd3, 13'd2,   2'd0, 1'b0},  // R7 exact
    '{16'h0038, 9'd64,  2'd0, 13'd24,  2'd3, 1'b0},  // R8 stride 3
    '{16'h0064, 9'd16,  2'd1, 13'd24,  2'd1, 1'b0},  // R8 stride 1
    '{16'h0F01, 9'd16,  2'd0, 13'd0,   2'd0, 1'b0},  // R5 high bits masked
    '{16'h0F01, 9'd256, 2'd0, 13'd896, 2'd0, 1'b0},  // R5 wide length
    '{16'h8038, 9'd64,  2'd0, 13'd24,  2'd3, 1'b1},  // R10 inverted stride
    '{16'h0302, 9'd128, 2'd1, 13'd192, 2'd0, 1'b0},  // R5 code 1 long
    '{16'h003C, 9'd32,  2'd3, 13'd4,   2'd0, 1'b0}   // R7 code 2 to 3
  };

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   ctr_word = '0;
  logic [VW-1:0] vl_bytes = 9'd16;
  logic [1:0]    elem_size = '0;
  logic          out_valid;
  logic [CW-1:0] out_count;
  logic [1:0]    out_lg2_stride;
  logic          out_invert;
  logic [NB-1:0] out_mask;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  always #5 clk = ~clk;

  pred_counter_decoder i_pred_counter_decoder (
    .clk            (clk),
    .arst_n         (arst_n),
    .in_valid       (in_valid),
    .ctr_word       (ctr_word),
    .vl_bytes       (vl_bytes),
    .elem_size      (elem_size),
    .out_valid      (out_valid),
    .out_count      (out_count),
    .out_lg2_stride (out_lg2_stride),
    .out_invert     (out_invert),
    .out_mask       (out_mask)
  );

  function automatic logic [NB-1:0] model_mask(input int cnt, input int stride,
                                               input bit inv, input int vl, input int esz);
    logic [NB-1:0] m = '0;
    int lim = vl >> esz;
    for (int i = 0; i < NB; i++) begin
      if (i < lim) m[i] = ((i < cnt) && (i % (1 << stride) == 0)) ^ inv;
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] c, input logic [VW-1:0] v, input logic [1:0] e,
                       input logic strobe);
    @(negedge clk);
    ctr_word  = c;
    vl_bytes  = v;
    elem_size = e;
    in_valid  = strobe;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] hold_cnt;
    logic [NB-1:0] hold_mask;
    logic          hold_inv;

    repeat (3) @(negedge clk);
    check(!out_valid && out_count == 0 && out_mask == '0, "R1 in reset",
          {out_valid, out_count}, '0);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!out_valid && out_count == 0 && !out_invert && out_lg2_stride == 0 && out_mask == '0,
          "R1 after release", {out_valid, out_invert, out_count}, '0);

    for (int v = 0; v < NVEC; v++) begin
      logic [NB-1:0] em;
      drive(VECS[v].ctr, VECS[v].vl, VECS[v].esz, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      em = model_mask(int'(VECS[v].cnt), int'(VECS[v].stride), VECS[v].inv,
                      int'(VECS[v].vl), int'(VECS[v].esz));
      check(out_valid == 1'b1, "R2 valid after strobe", NB'(out_valid), NB'(1));
      check(out_count == VECS[v].cnt, "R4 R5 R7 R8 count", NB'(out_count), NB'(VECS[v].cnt));
      check(out_lg2_stride == VECS[v].stride, "R8 stride", NB'(out_lg2_stride),
            NB'(VECS[v].stride));
      check(out_invert == VECS[v].inv, "R3 R6 invert", NB'(out_invert), NB'(VECS[v].inv));
      check(out_mask == em, "R9 R10 mask", out_mask, em);
    end

    // R2: single-cycle valid, then inputs change without strobe
    hold_cnt  = out_count;
    hold_mask = out_mask;
    hold_inv  = out_invert;
    drive(16'h8015, 9'd16, 2'd0, 1'b0);
    check(!out_valid, "R2 valid drops", NB'(out_valid), '0);
    repeat (2) @(negedge clk);
    check(out_count == hold_cnt && out_mask == hold_mask && out_invert == hold_inv && !out_valid,
          "R2 hold without strobe", NB'(out_count), NB'(hold_cnt));

    // R2: back-to-back strobes
    drive(16'h0015, 9'd16, 2'd0, 1'b1);
    drive(16'h0016, 9'd32, 2'd1, 1'b1);
    check(out_valid && out_count == 13'd10, "R2 first of pair", NB'(out_count), NB'(10));
    drive(16'h0000, 9'd16, 2'd0, 1'b0);
    check(out_valid && out_count == 13'd5, "R2 second of pair", NB'(out_count), NB'(5));
    @(negedge clk);
    check(!out_valid, "R2 pair valid drops", NB'(out_valid), '0);

    // R3: empty marker with every other bit set
    drive(16'hFFF0, 9'd256, 2'd2, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_count == 0 && !out_invert && out_mask == '0, "R3 all upper bits",
          {out_invert, out_count}, '0);

    // R1: asynchronous reset mid-run
    drive(16'h8015, 9'd16, 2'd0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    arst_n   = 1'b0;
    #1;
    check(!out_valid && out_count == 0 && !out_invert && out_mask == '0, "R1 async clear",
          {out_valid, out_invert, out_count}, '0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule